// File: doc/BRIEF.md
# Keyboard Link Responder

This block plays the keyboard end of a byte-wide host link. The host sends command bytes. The block answers by placing reply bytes into a receive queue, which the host drains through a simple read port. Key events arrive separately as set-1 scan codes. Each one is mapped to an output key code through one of two 128-entry lookup tables, supplied as parameters: a normal table and a table for prefixed (extended) codes. The mapped code is then appended to the same queue.

Caps-lock and num-lock events are filtered so that a lock key behaves as a toggle toward the host. The first press and the second release get through; the release in between and the second press are discarded. A command byte and a scan code may arrive in the same cycle. In that case, the reply to the command lands in the queue ahead of the key code. Everything is processed in the cycle it arrives. Up to four bytes can enter the queue on one clock edge.

Top module: `kbd_link_responder`

## Requirements
- R1: After reset the queue is empty: `qLevel` is 0, `rdValid` is 0 and `rdData` reads 0.
- R2: Command byte 0x01 empties the queue, then appends 0xFF, 0x04, 0x7F in that order, even when the queue was full.
- R3: Command byte 0x0E arms an argument skip. The next command byte, whatever its value, is discarded with no effect on the queue, and the skip is then disarmed.
- R4: Command bytes 0x07 and 0x0F empty the queue, then append 0xFE, 0x00. Any other command byte leaves the queue unchanged.
- R5: Scan code 0xE0 puts nothing in the queue. It marks only the next translated scan code for lookup in the extended table; the code after that uses the normal table again.
- R6: A scan code other than 0xE0 appends one byte: the table entry at index scan[6:0], with scan[7] ORed into bit 7 as the release flag.
- R7: Caps lock (press 0x3A, release 0xBA) has a 2-bit state starting at 0. A press flips bit 0 and is dropped if the result is 2. A release flips bit 1 and is dropped if the result is 3. Repeated press/release pairs therefore pass, drop, drop, pass.
- R8: Num lock (press 0x45, release 0xC5) follows the same rule as R7 with its own independent state.
- R9: When a command and a scan code arrive in the same cycle, the command's reply bytes enter the queue before the translated scan byte.
- R10: The queue is first-in first-out. `rdData` shows the oldest entry while `rdValid` is 1. A pulse on `popReq` removes that entry. A pop on an empty queue has no effect.
- R11: The queue holds DEPTH (256) bytes. Bytes that arrive while it is full are dropped, and `qLevel` never exceeds DEPTH.
- R12: Reset also clears the extended-prefix mark, the armed argument skip and both lock states.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command byte strobe |
| cmdByte | input | 8 | Command byte from the host |
| scanValid | input | 1 | Scan code strobe |
| scanByte | input | 8 | Set-1 scan code |
| popReq | input | 1 | Remove the oldest queue entry |
| rdData | output | 8 | Oldest queue entry, 0 when empty |
| rdValid | output | 1 | Queue not empty |
| qLevel | output | 9 | Number of bytes in the queue |

## Verification
The bench targets the ordering corner where a flushing command and a scan code land together. A design that wrote the scan byte first, or let the flush erase it, would show the wrong head or a level of 2. It feeds an identify command as the byte right after the LED command; a design that did not swallow it would refill the queue with 0xFF. It walks two full press/release cycles of each lock key and leaves a lock state at 1 across a reset, so a design with a wrong drop rule or an uncleared state emits or loses a release. It fills the queue to 256 and adds one more byte, which an off-by-one capacity check would accept or let wrap over the head.

// File: rtl/kbd_link_pkg.sv
package kbd_link_pkg;

  localparam int BYTE_W      = 8;
  localparam int MAP_ENTRIES = 128;
  localparam int MAP_W       = MAP_ENTRIES * BYTE_W;
  localparam int MAX_RESP    = 3;
  localparam int LANES       = MAX_RESP + 1;
  localparam int NWR_W       = $clog2(LANES + 1);

  // host command codes
  localparam logic [7:0] CMD_IDENT    = 8'h01;
  localparam logic [7:0] CMD_LEDS     = 8'h0E;
  localparam logic [7:0] CMD_LAYOUT_A = 8'h07;
  localparam logic [7:0] CMD_LAYOUT_B = 8'h0F;

  // reply bytes
  localparam logic [7:0] RSP_IDENT_HDR  = 8'hFF;
  localparam logic [7:0] RSP_IDENT_TYPE = 8'h04;
  localparam logic [7:0] RSP_IDENT_END  = 8'h7F;
  localparam logic [7:0] RSP_LAYOUT_HDR = 8'hFE;
  localparam logic [7:0] RSP_LAYOUT_VAL = 8'h00;

  // scan codes with special handling
  localparam logic [7:0] SCAN_EXT_PREFIX = 8'hE0;
  localparam logic [7:0] KEY_CAPS_DN     = 8'd58;
  localparam logic [7:0] KEY_CAPS_UP     = 8'd186;
  localparam logic [7:0] KEY_NUM_DN      = 8'd69;
  localparam logic [7:0] KEY_NUM_UP      = 8'd197;

  typedef struct packed {
    logic                           flushQ;
    logic [1:0]                     respLen;
    logic [MAX_RESP-1:0][BYTE_W-1:0] respByte;
    logic                           scanPush;
    logic                           scanExt;
    logic [BYTE_W-1:0]              scanCode;
  } ctrlStrobe_t;

  function automatic logic [MAP_W-1:0] defaultMap(input int salt);
    logic [MAP_W-1:0] m;
    for (int i = 0; i < MAP_ENTRIES; i++) begin
      m[i*BYTE_W +: BYTE_W] = 8'((i + salt) % MAP_ENTRIES);
    end
    return m;
  endfunction

endpackage

// File: rtl/kbd_link_ctrl.sv
module kbd_link_ctrl
  import kbd_link_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [7:0]  cmdByte,
  input  logic        scanValid,
  input  logic [7:0]  scanByte,
  output ctrlStrobe_t strobe
);

  logic       ledMode, ledNext;
  logic       extFlag, extNext;
  logic [1:0] capsState, capsNext;
  logic [1:0] numState, numNext;
  logic [2:0] capsStep, numStep;
  logic       dropScan;

  // returns {drop, nextState}
  function automatic logic [2:0] lockStep(input logic [1:0] st, input logic isPress);
    logic [1:0] nxt;
    nxt = isPress ? (st ^ 2'b01) : (st ^ 2'b10);
    return {(isPress ? (nxt == 2'b10) : (nxt == 2'b11)), nxt};
  endfunction

  always_comb begin
    capsStep = lockStep(capsState, scanByte == KEY_CAPS_DN);
    numStep  = lockStep(numState,  scanByte == KEY_NUM_DN);
  end

  always_comb begin
    strobe   = '0;
    ledNext  = ledMode;
    extNext  = extFlag;
    capsNext = capsState;
    numNext  = numState;
    dropScan = 1'b0;

    if (cmdValid) begin
      if (ledMode) begin
        ledNext = 1'b0;
      end else begin
        case (cmdByte)
          CMD_IDENT: begin
            strobe.flushQ      = 1'b1;
            strobe.respLen     = 2'd3;
            strobe.respByte[0] = RSP_IDENT_HDR;
            strobe.respByte[1] = RSP_IDENT_TYPE;
            strobe.respByte[2] = RSP_IDENT_END;
          end
          CMD_LEDS: ledNext = 1'b1;
          CMD_LAYOUT_A, CMD_LAYOUT_B: begin
            strobe.flushQ      = 1'b1;
            strobe.respLen     = 2'd2;
            strobe.respByte[0] = RSP_LAYOUT_HDR;
            strobe.respByte[1] = RSP_LAYOUT_VAL;
          end
          default: ;
        endcase
      end
    end

    if (scanValid) begin
      if (scanByte == SCAN_EXT_PREFIX) begin
        extNext = 1'b1;
      end else begin
        case (scanByte)
          KEY_CAPS_DN, KEY_CAPS_UP: begin
            capsNext = capsStep[1:0];
            dropScan = capsStep[2];
          end
          KEY_NUM_DN, KEY_NUM_UP: begin
            numNext  = numStep[1:0];
            dropScan = numStep[2];
          end
          default: ;
        endcase
        if (!dropScan) begin
          strobe.scanPush = 1'b1;
          strobe.scanExt  = extFlag;
          strobe.scanCode = scanByte;
          extNext         = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ledMode   <= 1'b0;
      extFlag   <= 1'b0;
      capsState <= 2'b00;
      numState  <= 2'b00;
    end else begin
      ledMode   <= ledNext;
      extFlag   <= extNext;
      capsState <= capsNext;
      numState  <= numNext;
    end
  end

  AST_LED_SWALLOW: assert property (@(posedge clk) disable iff (!rstN)
    (ledMode && cmdValid) |-> (!strobe.flushQ && strobe.respLen == 2'd0)); // R3
  AST_LED_DISARM: assert property (@(posedge clk) disable iff (!rstN)
    (ledMode && cmdValid) |=> !ledMode); // R3
  AST_PREFIX_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (scanValid && scanByte == SCAN_EXT_PREFIX) |-> !strobe.scanPush); // R5
  AST_EXT_ONESHOT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.scanPush |=> !extFlag); // R5

endmodule

// File: rtl/kbd_link_fifo.sv
module kbd_link_fifo
  import kbd_link_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   flush,
  input  logic                   pop,
  input  logic [NWR_W-1:0]       nWr,
  input  logic [LANES-1:0][7:0]  wrBytes,
  output logic [7:0]             rdData,
  output logic                   rdValid,
  output logic [LVL_W-1:0]       level
);

  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] rdPtr, wrPtr, wBase;
  logic [LVL_W-1:0] base, room, want, acc;
  logic             popOk;

  always_comb begin
    base  = flush ? '0 : level;
    wBase = flush ? '0 : wrPtr;
    room  = LVL_W'(DEPTH) - base;
    want  = LVL_W'(nWr);
    acc   = (want > room) ? room : want;
    popOk = pop && !flush && (level != '0);
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (LVL_W'(i) < acc) mem[wBase + PTR_W'(i)] <= wrBytes[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      level <= '0;
    end else begin
      rdPtr <= flush ? '0 : (rdPtr + PTR_W'(popOk));
      wrPtr <= wBase + PTR_W'(acc);
      level <= base - LVL_W'(popOk) + acc;
    end
  end

  assign rdValid = (level != '0);
  assign rdData  = rdValid ? mem[rdPtr] : 8'h00;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    level <= LVL_W'(DEPTH)); // R11
  AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (pop && level == '0 && nWr == '0 && !flush) |=> (level == '0)); // R10
  AST_GROW_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    !flush |=> (level <= $past(level) + LVL_W'(LANES))); // R10

endmodule

// File: rtl/kbd_link_datapath.sv
module kbd_link_datapath
  import kbd_link_pkg::*;
#(
  parameter int               DEPTH    = 256,
  parameter logic [MAP_W-1:0] NORM_MAP = defaultMap(0),
  parameter logic [MAP_W-1:0] EXT_MAP  = defaultMap(64),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic             popReq,
  output logic [7:0]       rdData,
  output logic             rdValid,
  output logic [LVL_W-1:0] qLevel
);

  logic [6:0]             mapIdx;
  logic [7:0]             normEntry, extEntry, mapped;
  logic [LANES-1:0][7:0]  laneByte;
  logic [NWR_W-1:0]       nWr;

  always_comb begin
    mapIdx    = strobe.scanCode[6:0];
    normEntry = NORM_MAP[{mapIdx, 3'b000} +: 8];
    extEntry  = EXT_MAP[{mapIdx, 3'b000} +: 8];
    mapped    = (strobe.scanExt ? extEntry : normEntry) | {strobe.scanCode[7], 7'b0};
    nWr       = NWR_W'(strobe.respLen) + NWR_W'(strobe.scanPush);
  end

  // reply bytes occupy the low lanes, the key code follows them
  for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
    if (gi < MAX_RESP) begin : g_resp
      assign laneByte[gi] = (2'(gi) < strobe.respLen) ? strobe.respByte[gi] : mapped;
    end else begin : g_key
      assign laneByte[gi] = mapped;
    end
  end

  kbd_link_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rstN    (rstN),
    .flush   (strobe.flushQ),
    .pop     (popReq),
    .nWr     (nWr),
    .wrBytes (laneByte),
    .rdData  (rdData),
    .rdValid (rdValid),
    .level   (qLevel)
  );

  AST_FLUSH_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flushQ |=> (qLevel <= LVL_W'(LANES))); // R2
  AST_ORDER_HEAD: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.flushQ && strobe.respLen != 2'd0) |=> (rdData == $past(strobe.respByte[0]))); // R9

endmodule

// File: rtl/kbd_link_responder.sv
module kbd_link_responder
  import kbd_link_pkg::*;
#(
  parameter int               DEPTH    = 256,
  parameter logic [MAP_W-1:0] NORM_MAP = defaultMap(0),
  parameter logic [MAP_W-1:0] EXT_MAP  = defaultMap(64),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [7:0]       cmdByte,
  input  logic             scanValid,
  input  logic [7:0]       scanByte,
  input  logic             popReq,
  output logic [7:0]       rdData,
  output logic             rdValid,
  output logic [LVL_W-1:0] qLevel
);

  ctrlStrobe_t strobe;

  kbd_link_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .cmdByte   (cmdByte),
    .scanValid (scanValid),
    .scanByte  (scanByte),
    .strobe    (strobe)
  );

  kbd_link_datapath #(
    .DEPTH    (DEPTH),
    .NORM_MAP (NORM_MAP),
    .EXT_MAP  (EXT_MAP)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .popReq  (popReq),
    .rdData  (rdData),
    .rdValid (rdValid),
    .qLevel  (qLevel)
  );

endmodule

// File: tb/kbd_link_responder_test.sv
module kbd_link_responder_test;

  localparam int OP_CMD = 0, OP_SCAN = 1, OP_POP = 2, OP_BOTH = 3;

  function automatic logic [7:0] nVal(input int i);
    return 8'((i * 37 + 11) % 128);
  endfunction
  function automatic logic [7:0] eVal(input int i);
    return 8'((i * 53 + 5) % 128);
  endfunction
  function automatic logic [1023:0] benchMap(input int sel);
    logic [1023:0] m;
    for (int i = 0; i < 128; i++) m[i*8 +: 8] = (sel != 0) ? eVal(i) : nVal(i);
    return m;
  endfunction

  typedef struct packed {
    logic [1:0] op;
    logic [7:0] dat;
    logic [8:0] lvl;
    logic [7:0] head;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 43;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 8'h1E, 9'd1, nVal(30), 4'd6},          // R6 press
    '{2'd1, 8'h9E, 9'd2, nVal(30), 4'd6},          // R6 release
    '{2'd2, 8'h00, 9'd1, nVal(30) | 8'h80, 4'd10}, // R10 fifo order
    '{2'd2, 8'h00, 9'd0, 8'h00, 4'd10},            // R10 drained
    '{2'd2, 8'h00, 9'd0, 8'h00, 4'd10},            // R10 pop on empty
    '{2'd1, 8'hE0, 9'd0, 8'h00, 4'd5},             // R5 prefix silent
    '{2'd1, 8'h48, 9'd1, eVal(72), 4'd5},          // R5 extended lookup
    '{2'd1, 8'h48, 9'd2, eVal(72), 4'd5},          // R5 one shot
    '{2'd2, 8'h00, 9'd1, nVal(72), 4'd5},
    '{2'd2, 8'h00, 9'd0, 8'h00, 4'd10},
    '{2'd0, 8'h01, 9'd3, 8'hFF, 4'd2},             // R2 identify
    '{2'd2, 8'h00, 9'd2, 8'h04, 4'd2},
    '{2'd2, 8'h00, 9'd1, 8'h7F, 4'd2},
    '{2'd1, 8'h1E, 9'd2, 8'h7F, 4'd6},
    '{2'd0, 8'h07, 9'd2, 8'hFE, 4'd4},             // R4 layout flushes
    '{2'd2, 8'h00, 9'd1, 8'h00, 4'd4},
    '{2'd0, 8'h0F, 9'd2, 8'hFE, 4'd4},             // R4 second code
    '{2'd0, 8'h55, 9'd2, 8'hFE, 4'd4},             // R4 unknown ignored
    '{2'd0, 8'h0E, 9'd2, 8'hFE, 4'd3},             // R3 arm
    '{2'd0, 8'h01, 9'd2, 8'hFE, 4'd3},             // R3 swallowed
    '{2'd0, 8'h01, 9'd3, 8'hFF, 4'd3},             // R3 disarmed
    '{2'd0, 8'h0E, 9'd3, 8'hFF, 4'd3},
    '{2'd0, 8'h07, 9'd3, 8'hFF, 4'd3},
    '{2'd3, 8'h0F, 9'd3, 8'hFE, 4'd9},             // R9 same cycle
    '{2'd2, 8'h00, 9'd2, 8'h00, 4'd9},
    '{2'd2, 8'h00, 9'd1, nVal(30), 4'd9},
    '{2'd2, 8'h00, 9'd0, 8'h00, 4'd9},
    '{2'd1, 8'h3A, 9'd1, nVal(58), 4'd7},          // R7 pass
    '{2'd1, 8'hBA, 9'd1, nVal(58), 4'd7},          // R7 drop
    '{2'd1, 8'h3A, 9'd1, nVal(58), 4'd7},          // R7 drop
    '{2'd1, 8'hBA, 9'd2, nVal(58), 4'd7},          // R7 pass
    '{2'd2, 8'h00, 9'd1, nVal(58) | 8'h80, 4'd7},
    '{2'd2, 8'h00, 9'd0, 8'h00, 4'd7},
    '{2'd1, 8'h45, 9'd1, nVal(69), 4'd8},          // R8 pass
    '{2'd1, 8'hC5, 9'd1, nVal(69), 4'd8},          // R8 drop
    '{2'd1, 8'h45, 9'd1, nVal(69), 4'd8},          // R8 drop
    '{2'd1, 8'hC5, 9'd2, nVal(69), 4'd8},          // R8 pass
    '{2'd2, 8'h00, 9'd1, nVal(69) | 8'h80, 4'd8},
    '{2'd2, 8'h00, 9'd0, 8'h00, 4'd8},
    '{2'd1, 8'h3A, 9'd1, nVal(58), 4'd7},          // R7 caps alone
    '{2'd1, 8'h45, 9'd2, nVal(58), 4'd8},          // R8 independent state
    '{2'd2, 8'h00, 9'd1, nVal(69), 4'd8},
    '{2'd2, 8'h00, 9'd0, 8'h00, 4'd10}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0, scanValid = 1'b0, popReq = 1'b0;
  logic [7:0] cmdByte = 8'h00, scanByte = 8'h00;
  logic [7:0] rdData;
  logic       rdValid;
  logic [8:0] qLevel;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  kbd_link_responder #(
    .DEPTH    (256),
    .NORM_MAP (benchMap(0)),
    .EXT_MAP  (benchMap(1))
  ) uut (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .cmdByte   (cmdByte),
    .scanValid (scanValid),
    .scanByte  (scanByte),
    .popReq    (popReq),
    .rdData    (rdData),
    .rdValid   (rdValid),
    .qLevel    (qLevel)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic checkState(input string tag, input int lvl, input int head);
    check({tag, " level"}, int'(qLevel), lvl);
    check({tag, " head"}, int'(rdData), head);
    check({tag, " valid"}, int'(rdValid), int'(lvl != 0));
  endtask

  task automatic doOp(input int op, input logic [7:0] dat);
    @(negedge clk);
    cmdValid  = (op == OP_CMD) || (op == OP_BOTH);
    cmdByte   = dat;
    scanValid = (op == OP_SCAN) || (op == OP_BOTH);
    scanByte  = (op == OP_BOTH) ? 8'h1E : dat;
    popReq    = (op == OP_POP);
    @(negedge clk);
    cmdValid  = 1'b0;
    scanValid = 1'b0;
    popReq    = 1'b0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checkState("R1 reset", 0, 0);
    rstN = 1'b1;
    @(negedge clk);
    checkState("R1 after release", 0, 0);

    for (int v = 0; v < NV; v++) begin
      doOp(int'(VECS[v].op), VECS[v].dat);
      checkState($sformatf("R%0d vector %0d", VECS[v].req, v),
                 int'(VECS[v].lvl), int'(VECS[v].head));
    end

    // R12: caps and num now at state 1; arm prefix and argument skip, then reset
    doOp(OP_SCAN, 8'hE0);
    doOp(OP_CMD, 8'h0E);
    @(negedge clk) rstN = 1'b0;
    repeat (2) @(negedge clk);
    checkState("R1 mid-run reset", 0, 0);
    rstN = 1'b1;
    doOp(OP_CMD, 8'h01);
    checkState("R12 skip cleared", 3, 8'hFF);
    for (int k = 0; k < 3; k++) doOp(OP_POP, 8'h00);
    doOp(OP_SCAN, 8'h48);
    checkState("R12 prefix cleared", 1, int'(nVal(72)));
    doOp(OP_POP, 8'h00);
    doOp(OP_SCAN, 8'hBA);
    checkState("R12 caps cleared", 1, int'(nVal(58) | 8'h80));
    doOp(OP_POP, 8'h00);
    doOp(OP_SCAN, 8'hC5);
    checkState("R12 num cleared", 1, int'(nVal(69) | 8'h80));
    doOp(OP_POP, 8'h00);

    // R11: fill to capacity, then one extra byte must be dropped
    for (int k = 0; k < 256; k++) doOp(OP_SCAN, 8'h1E);
    checkState("R11 full", 256, int'(nVal(30)));
    doOp(OP_SCAN, 8'h9E);
    checkState("R11 drop when full", 256, int'(nVal(30)));
    for (int k = 0; k < 255; k++) doOp(OP_POP, 8'h00);
    checkState("R11 extra byte absent", 1, int'(nVal(30)));
    doOp(OP_SCAN, 8'h1E);
    for (int k = 0; k < 255; k++) doOp(OP_SCAN, 8'h1E);
    doOp(OP_CMD, 8'h01);
    checkState("R2 identify on full queue", 3, 8'hFF);

    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

endmodule